// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Alternate Pin Functions

This block is an eight-pin general-purpose port for a small microcontroller. It sits on a simple register bus that has an address, a write strobe, write data and combinational read data. It has no direction register. Each pin has an output latch. A latched 0 pulls the pad low with a strong driver. A latched 1 leaves the pad on a weak pull-up, so the pin can also act as an input. A read of the port register returns the synchronized level at the pads, not the latch contents.

Pins can be given to other functions. Each of the low six pins can carry one analog-converter pulse channel, and each has its own active-low select bit in a write-only enable register. Pin 6 can carry a vertical sync output and pin 7 a horizontal sync output, each selected by an active-low bit in a sync control register. The sync control register also holds the two output polarity bits. On reads it reports the sync input levels and the detected input polarities.

When a pin's latch goes from 0 to 1, the pad gets a strong-high assist for one clock to speed up the rising edge. The latch keeps its value while a pin serves another function.

Top module: `qbio_port`

## Requirements
- R1: After a synchronous active-high reset, all pads sit on pull-up with no drive low, both polarity outputs are 1, and every pin is in plain I/O mode.
- R2: In I/O mode a pin whose latch is 0 has padDriveLow=1 with padPullUp=0 and padDriveHigh=0. A latched 1 gives padPullUp=1 and padDriveLow=0. No pad ever asserts drive-low together with pull-up or drive-high.
- R3: A write to the port register (address 0x0) that changes a latch bit from 0 to 1 asserts padDriveHigh for that pin during exactly the one cycle after the write edge. Rewriting a 1 over a 1, or a 0 to 1 change on a pin held by another function, gives no assist.
- R4: A port read (address 0x0) returns the padIn levels through a two-stage synchronizer. A pad change is visible after the second rising edge and not after the first.
- R5: When bit k (k = 0..5) of the enable register at address 0xF is 0, pin k carries dacIn[k]. A 0 drives low, and a 1 gives drive-high plus pull-up. The latch value has no effect on the pad.
- R6: Sync control register (address 0x7) bit 6 = 0 routes vsyncSrc to pin 6, and bit 7 = 0 routes hsyncSrc to pin 7. Writing these bits back to 1 returns the pins to I/O.
- R7: Sync control bits 1 and 0 drive hPolOut and vPolOut. A read of address 0x7 returns {1, 1, hsyncIn, vsyncIn, hPolIn, vPolIn, hPolOut, vPolOut}, from bit 7 down to bit 0. Writes to bits 5..2 have no effect.
- R8: The latch holds its value while a pin serves another function. Returning the pin to I/O drives it from that value, including latch writes made while the pin was away.
- R9: The enable register reads back 0xFF. Its bits 7..6 are ignored. Addresses other than 0x0 and 0x7 read 0xFF, and writes to them change nothing.
- R10: A register changes only at a rising edge where busWr is high with its address selected. With busWr low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 4 | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational on busAddr) |
| dacIn | input | 6 | Pulse channel levels for pins 0..5 |
| vsyncSrc | input | 1 | Vertical sync output level for pin 6 |
| hsyncSrc | input | 1 | Horizontal sync output level for pin 7 |
| hsyncIn | input | 1 | Horizontal sync input level, read-only status |
| vsyncIn | input | 1 | Vertical sync input level, read-only status |
| hPolIn | input | 1 | Detected horizontal input polarity |
| vPolIn | input | 1 | Detected vertical input polarity |
| padIn | input | 8 | Pad levels seen by the input buffers |
| padDriveLow | output | 8 | Strong low driver enable per pin |
| padDriveHigh | output | 8 | Strong high driver enable per pin |
| padPullUp | output | 8 | Weak pull-up enable per pin |
| hPolOut | output | 1 | Horizontal output polarity bit |
| vPolOut | output | 1 | Vertical output polarity bit |

## Verification
The port latch is written with a checkerboard value from an all-ones state, then restored to all ones. The first write shows the strong-low and pull-up split. The second shows that only the bits that rose get the one-cycle assist. External pull-downs on a latched-high port show that reads return pad levels, and a sample after one edge and again after two pins down the synchronizer latency. Several dacIn patterns are tried with all, one, and none of the channels selected, and latch writes are made while the pins are away. These separate the latch, the alternate source and the stored value. Sync routing is tried with opposite levels on the two sync pins, with status inputs flipped, and with ones written to the read-only field. Unmapped addresses and idle strobes finish the run.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  // Write strobes from the decoder to the datapath, one per register.
  typedef struct packed {
    logic portWr;
    logic syncWr;
    logic dacWr;
  } regStrobe_t;

  // Bit positions in the sync control register (decoded by neighbours).
  localparam int unsigned SYNC_HEN_BIT  = 7;
  localparam int unsigned SYNC_VEN_BIT  = 6;
  localparam int unsigned SYNC_HPOL_BIT = 1;
  localparam int unsigned SYNC_VPOL_BIT = 0;
endpackage

// File: rtl/qbio_ctrl.sv
module qbio_ctrl
  import qbio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PORT_ADDR = 0,
  parameter int unsigned SYNC_ADDR = 7,
  parameter int unsigned DAC_ADDR  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] portRead,
  input  logic [DATA_W-1:0] syncRead,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata
);
  localparam logic [ADDR_W-1:0] PORT_SEL = ADDR_W'(PORT_ADDR);
  localparam logic [ADDR_W-1:0] SYNC_SEL = ADDR_W'(SYNC_ADDR);
  localparam logic [ADDR_W-1:0] DAC_SEL  = ADDR_W'(DAC_ADDR);

  logic hitPort, hitSync, hitDac;

  always_comb begin
    hitPort = (busAddr == PORT_SEL);
    hitSync = (busAddr == SYNC_SEL);
    hitDac  = (busAddr == DAC_SEL);
  end

  always_comb begin
    strobe.portWr = busWr & hitPort;
    strobe.syncWr = busWr & hitSync;
    strobe.dacWr  = busWr & hitDac;
  end

  // Enable register is write-only; it and unmapped space read as ones.
  always_comb begin
    if (hitPort)      busRdata = portRead;
    else if (hitSync) busRdata = syncRead;
    else              busRdata = '1;
  end

  // R10: at most one register is written per cycle.
  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.portWr, strobe.syncWr, strobe.dacWr}));
endmodule

// File: rtl/qbio_datapath.sv
module qbio_datapath
  import qbio_pkg::*;
#(
  parameter int unsigned PIN_W      = 8,
  parameter int unsigned DAC_N      = 6,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  regStrobe_t       strobe,
  input  logic [PIN_W-1:0] busWdata,
  input  logic [DAC_N-1:0] dacIn,
  input  logic             vsyncSrc,
  input  logic             hsyncSrc,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic             hPolIn,
  input  logic             vPolIn,
  input  logic [PIN_W-1:0] padIn,
  output logic [PIN_W-1:0] padDriveLow,
  output logic [PIN_W-1:0] padDriveHigh,
  output logic [PIN_W-1:0] padPullUp,
  output logic [PIN_W-1:0] portRead,
  output logic [PIN_W-1:0] syncRead,
  output logic             hPolOut,
  output logic             vPolOut
);
  localparam int unsigned VS_PIN  = DAC_N;
  localparam int unsigned HS_PIN  = DAC_N + 1;
  localparam int unsigned STAT_W  = 6;
  localparam int unsigned FILL_W  = PIN_W - STAT_W;

  logic [PIN_W-1:0] latchQ;
  logic [PIN_W-1:0] assistQ;
  logic [DAC_N-1:0] dacEnN;
  logic             hEnN, vEnN, hPolQ, vPolQ;
  logic [PIN_W-1:0] altSel, altVal;
  logic [PIN_W-1:0] syncStage [SYNC_DEPTH];

  // Port latch and rising-edge assist.
  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ  <= '1;
      assistQ <= '0;
    end else if (strobe.portWr) begin
      latchQ  <= busWdata;
      assistQ <= busWdata & ~latchQ & ~altSel;
    end else begin
      assistQ <= '0;
    end
  end

  // Alternate-function enables (active low) and sync polarity bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      dacEnN <= '1;
      hEnN   <= 1'b1;
      vEnN   <= 1'b1;
      hPolQ  <= 1'b1;
      vPolQ  <= 1'b1;
    end else begin
      if (strobe.dacWr) dacEnN <= busWdata[DAC_N-1:0];
      if (strobe.syncWr) begin
        hEnN  <= busWdata[SYNC_HEN_BIT];
        vEnN  <= busWdata[SYNC_VEN_BIT];
        hPolQ <= busWdata[SYNC_HPOL_BIT];
        vPolQ <= busWdata[SYNC_VPOL_BIT];
      end
    end
  end

  // Per-pin alternate source selection.
  for (genvar i = 0; i < PIN_W; i++) begin : g_alt
    if (i < DAC_N) begin : g_dac
      assign altSel[i] = ~dacEnN[i];
      assign altVal[i] = dacIn[i];
    end else if (i == VS_PIN) begin : g_vs
      assign altSel[i] = ~vEnN;
      assign altVal[i] = vsyncSrc;
    end else begin : g_hs
      assign altSel[i] = ~hEnN;
      assign altVal[i] = hsyncSrc;
    end
  end

  // Pad control.
  always_comb begin
    for (int i = 0; i < PIN_W; i++) begin
      if (altSel[i]) begin
        padDriveLow[i]  = ~altVal[i];
        padDriveHigh[i] = altVal[i];
        padPullUp[i]    = altVal[i];
      end else begin
        padDriveLow[i]  = ~latchQ[i];
        padDriveHigh[i] = latchQ[i] & assistQ[i];
        padPullUp[i]    = latchQ[i];
      end
    end
  end

  // Pin input synchronizer.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_DEPTH; s++) syncStage[s] <= '1;
    end else begin
      syncStage[0] <= padIn;
      for (int s = 1; s < SYNC_DEPTH; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  always_comb begin
    portRead = syncStage[SYNC_DEPTH-1];
    syncRead = {{FILL_W{1'b1}}, hsyncIn, vsyncIn, hPolIn, vPolIn, hPolQ, vPolQ};
    hPolOut  = hPolQ;
    vPolOut  = vPolQ;
  end

  // R2: a strong low never overlaps pull-up or strong high.
  p_low_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    (padDriveLow & (padDriveHigh | padPullUp)) == '0);

  // R3: the assist never lasts two consecutive cycles on one pin.
  p_assist_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (assistQ & $past(assistQ)) == '0);

  // R10: latch holds without a port write strobe.
  p_latch_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !strobe.portWr |=> $stable(latchQ));

  // R9: enable register holds without its strobe.
  p_dacen_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.dacWr |=> $stable(dacEnN));
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int unsigned PIN_W      = 8,
  parameter int unsigned DAC_N      = 6,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned PORT_ADDR  = 0,
  parameter int unsigned SYNC_ADDR  = 7,
  parameter int unsigned DAC_ADDR   = 15,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [PIN_W-1:0]  busWdata,
  output logic [PIN_W-1:0]  busRdata,
  input  logic [DAC_N-1:0]  dacIn,
  input  logic              vsyncSrc,
  input  logic              hsyncSrc,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic              hPolIn,
  input  logic              vPolIn,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padDriveLow,
  output logic [PIN_W-1:0]  padDriveHigh,
  output logic [PIN_W-1:0]  padPullUp,
  output logic              hPolOut,
  output logic              vPolOut
);
  regStrobe_t       strobe;
  logic [PIN_W-1:0] portRead, syncRead;

  qbio_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(PIN_W), .PORT_ADDR(PORT_ADDR),
    .SYNC_ADDR(SYNC_ADDR), .DAC_ADDR(DAC_ADDR)
  ) uCtrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr),
    .portRead(portRead), .syncRead(syncRead),
    .strobe(strobe), .busRdata(busRdata)
  );

  qbio_datapath #(
    .PIN_W(PIN_W), .DAC_N(DAC_N), .SYNC_DEPTH(SYNC_DEPTH)
  ) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .busWdata(busWdata),
    .dacIn(dacIn), .vsyncSrc(vsyncSrc), .hsyncSrc(hsyncSrc),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .hPolIn(hPolIn), .vPolIn(vPolIn),
    .padIn(padIn), .padDriveLow(padDriveLow), .padDriveHigh(padDriveHigh),
    .padPullUp(padPullUp), .portRead(portRead), .syncRead(syncRead),
    .hPolOut(hPolOut), .vPolOut(vPolOut)
  );
endmodule

// File: tb/sim_qbio_port.sv
`timescale 1ns/100ps
module sim_qbio_port;
  localparam int K_READ = 0, K_LOW = 1, K_HIGH = 2, K_PULL = 3, K_POL = 4;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 0, rst = 1;
  logic [3:0] busAddr = '0;
  logic       busWr = 0;
  logic [7:0] busWdata = '0, busRdata;
  logic [5:0] dacIn = '0;
  logic       vsyncSrc = 0, hsyncSrc = 0;
  logic       hsyncIn = 1, vsyncIn = 0, hPolIn = 1, vPolIn = 0;
  logic [7:0] padIn, padDriveLow, padDriveHigh, padPullUp;
  logic       hPolOut, vPolOut;
  logic [7:0] extLow = '0;

  item_t sb[$];
  event  sampleEv;
  int    vecCount = 0, errCount = 0;
  bit    done = 0;

  always #2 clk = ~clk;

  // Pad model: strong drivers win, otherwise an external pull-down beats the weak pull-up.
  always_comb begin
    for (int i = 0; i < 8; i++)
      padIn[i] = padDriveLow[i] ? 1'b0 : (padDriveHigh[i] ? 1'b1 : ~extLow[i]);
  end

  qbio_port u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .dacIn(dacIn), .vsyncSrc(vsyncSrc), .hsyncSrc(hsyncSrc),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .hPolIn(hPolIn), .vPolIn(vPolIn),
    .padIn(padIn), .padDriveLow(padDriveLow), .padDriveHigh(padDriveHigh),
    .padPullUp(padPullUp), .hPolOut(hPolOut), .vPolOut(vPolOut)
  );

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      @(sampleEv);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_READ:  act = busRdata;
          K_LOW:   act = padDriveLow;
          K_HIGH:  act = padDriveHigh;
          K_PULL:  act = padPullUp;
          default: act = {6'b0, hPolOut, vPolOut};
        endcase
        vecCount++;
        if (act !== it.exp) begin
          errCount++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic flush();
    #0.1;
    -> sampleEv;
    wait (sb.size() == 0);
  endtask

  task automatic expectPads(logic [7:0] lo, logic [7:0] hi, logic [7:0] pu, string req);
    expect_(K_LOW, lo, req);
    expect_(K_HIGH, hi, req);
    expect_(K_PULL, pu, req);
    flush();
  endtask

  task automatic readCheck(logic [3:0] a, logic [7:0] exp, string req);
    busAddr = a;
    expect_(K_READ, exp, req);
    flush();
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    expectPads(8'h00, 8'h00, 8'hFF, "R1");
    expect_(K_POL, 8'h03, "R1"); flush();
    readCheck(4'h0, 8'hFF, "R1");
    readCheck(4'h7, 8'hEB, "R7");
    readCheck(4'hF, 8'hFF, "R9");

    // R2 checkerboard from all ones: no bit rises, so no assist
    busWrite(4'h0, 8'h5A);
    expectPads(8'hA5, 8'h00, 8'h5A, "R2");
    repeat (2) @(negedge clk);
    readCheck(4'h0, 8'h5A, "R4");

    // R3 restore all ones: the rising bits get one cycle of assist
    busWrite(4'h0, 8'hFF);
    expectPads(8'h00, 8'hA5, 8'hFF, "R3");
    @(negedge clk);
    expectPads(8'h00, 8'h00, 8'hFF, "R3");
    busWrite(4'h0, 8'hFF);
    expectPads(8'h00, 8'h00, 8'hFF, "R3");

    // R4 synchronizer latency with external pull-downs
    repeat (2) @(negedge clk);
    extLow = 8'h3C;
    @(negedge clk);
    readCheck(4'h0, 8'hFF, "R4");
    @(negedge clk);
    readCheck(4'h0, 8'hC3, "R4");
    extLow = 8'h00;

    // R5 pulse channels: all selected, then one
    busWrite(4'h0, 8'h00);
    dacIn = 6'b101001;
    busWrite(4'hF, 8'hC0);
    expectPads(8'hD6, 8'h29, 8'h29, "R5");
    dacIn = 6'b010110;
    expectPads(8'hE9, 8'h16, 8'h16, "R5");
    readCheck(4'hF, 8'hFF, "R9");
    busWrite(4'hF, 8'hFE);
    expectPads(8'hFF, 8'h00, 8'h00, "R5");
    dacIn = 6'b000001;
    expectPads(8'hFE, 8'h01, 8'h01, "R5");

    // R8 latch writes while pins are away, then return to I/O
    dacIn = 6'b000000;
    busWrite(4'hF, 8'h00);
    busWrite(4'h0, 8'h3F);
    expectPads(8'hFF, 8'h00, 8'h00, "R8");
    busWrite(4'hF, 8'hFF);
    expectPads(8'hC0, 8'h00, 8'h3F, "R8");

    // R6 sync routing, R7 polarity and read-only field
    busWrite(4'h0, 8'hFF);
    @(negedge clk);
    vsyncSrc = 1; hsyncSrc = 0;
    busWrite(4'h7, 8'h3C);
    expectPads(8'h80, 8'h40, 8'h7F, "R6");
    expect_(K_POL, 8'h00, "R7"); flush();
    readCheck(4'h7, 8'hE8, "R7");
    hsyncIn = 0; vsyncIn = 1; hPolIn = 0; vPolIn = 1;
    readCheck(4'h7, 8'hD4, "R7");
    busWrite(4'h7, 8'hBF);
    expectPads(8'h00, 8'h40, 8'hFF, "R6");
    expect_(K_POL, 8'h03, "R7"); flush();

    // R9 unmapped addresses, R10 idle strobe
    busWrite(4'h7, 8'hFF);
    busWrite(4'h3, 8'h00);
    expectPads(8'h00, 8'h00, 8'hFF, "R9");
    readCheck(4'h3, 8'hFF, "R9");
    @(negedge clk);
    busAddr = 4'h0; busWdata = 8'h00; busWr = 0;
    repeat (2) @(negedge clk);
    expectPads(8'h00, 8'h00, 8'hFF, "R10");
    readCheck(4'h0, 8'hFF, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule